// File: doc/BRIEF.md
# Four-Phase Cross-Clock Word Transfer

This block moves data words from a sending clock domain into a receiving clock domain without any buffering. A word offered on the sending side with a valid/ready pair is latched onto a shared data bus, and a request line is raised. The receiving side sees the request through a synchronizer chain. It then samples the bus once, presents the word for exactly one cycle and raises an acknowledge line. The acknowledge travels back through its own synchronizer.

The exchange is return-to-zero. The sender drops its request only after it has seen the acknowledge. The receiver drops the acknowledge only after it has seen the request fall. The sender accepts the next word only after it has seen the acknowledge fall. Both control lines cross a clock boundary twice per word, so one transfer costs several cycles of each clock. This suits low-rate control or configuration words. Each domain has its own synchronous active-low reset.

Top module: `xdom_word_handshake`

## Requirements
- R1: After reset, `snd_ready` is 1 and `rcv_valid` is 0.
- R2: `snd_ready` is 1 only when the request line is low and the synchronized acknowledge is low. A word offered while `snd_ready` is 0 is not taken and never appears at the receiver.
- R3: In the cycle after a word is accepted (`snd_valid` and `snd_ready` both 1), the request line is high. It stays high until the synchronized acknowledge is seen.
- R4: The shared data bus holds the accepted word unchanged while the request line is high and the synchronized acknowledge is low.
- R5: Each transfer produces exactly one `rcv_valid` pulse, one receive-clock cycle wide, with `rcv_data` equal to the accepted word.
- R6: The acknowledge line rises together with the `rcv_valid` pulse. It stays high until the synchronized request is seen low, and then it falls.
- R7: After the request falls, the sender does not raise it again, and `snd_ready` stays 0, while the synchronized acknowledge is still high.
- R8: With unrelated clock periods, words arrive in the order they were accepted, with none lost and none repeated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| snd_clk | input | 1 | Sending domain clock |
| snd_rst_n | input | 1 | Sending domain synchronous active-low reset |
| snd_valid | input | 1 | A word is offered on `snd_data` |
| snd_data | input | DATA_W | Word to transfer |
| snd_ready | output | 1 | Sender idle; a word is taken when `snd_valid` is also 1 |
| rcv_clk | input | 1 | Receiving domain clock |
| rcv_rst_n | input | 1 | Receiving domain synchronous active-low reset |
| rcv_valid | output | 1 | One-cycle pulse marking a delivered word |
| rcv_data | output | DATA_W | Delivered word, valid while `rcv_valid` is 1 |

## Verification
Assertions check the local protocol rules of each side on every cycle:
- the request line is held until the acknowledge is seen, and is not re-raised while the acknowledge is still high;
- the bus is stable while the request is pending;
- the delivery pulse is one cycle wide and coincides with the rising acknowledge;
- the acknowledge is held until the request is seen low.

Only the bench scenarios can show the end-to-end properties. These are that each word arrives once, in order and with the right value, and that words offered while the sender is busy are dropped. The scenarios run with two unrelated clock periods, use random gaps and random data, and include directed back-to-back and extreme-value words.

// File: rtl/xdom_hs_pkg.sv
// Shared types for the cross-domain word handshake.
// Assumes: nothing beyond IEEE 1800-2017.
package xdom_hs_pkg;
    typedef enum logic [1:0] {
        SND_IDLE      = 2'd0,
        SND_WAIT_ACK  = 2'd1,
        SND_WAIT_DROP = 2'd2
    } snd_state_t;
endpackage

// File: rtl/xdom_bit_sync.sv
// Multi-flop synchronizer for a single control bit entering a clock domain.
// Assumes: the input is a level that changes at most once per several
// destination cycles; STAGES >= 2.
module xdom_bit_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the incoming level through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/xdom_hs_sender.sv
// Sending side: accepts a word when idle, holds it on the bus, runs the
// request half of the four-phase exchange.
// Assumes: ack_sync is already synchronized into snd_clk.
module xdom_hs_sender
    import xdom_hs_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    output logic              in_ready,
    input  logic              ack_sync,
    output logic              req,
    output logic [DATA_W-1:0] bus_data
);
    snd_state_t state;

    // Ready only when idle with both control lines low.
    assign in_ready = (state == SND_IDLE) && !req && !ack_sync;

    // Sequence the request phases and latch the accepted word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= SND_IDLE;
            req      <= 1'b0;
            bus_data <= '0;
        end else begin
            case (state)
                SND_IDLE: begin
                    if (in_valid && in_ready) begin
                        bus_data <= in_data;
                        req      <= 1'b1;
                        state    <= SND_WAIT_ACK;
                    end
                end
                SND_WAIT_ACK: begin
                    if (ack_sync) begin
                        req   <= 1'b0;
                        state <= SND_WAIT_DROP;
                    end
                end
                SND_WAIT_DROP: begin
                    if (!ack_sync) state <= SND_IDLE;
                end
                default: begin
                    state <= SND_IDLE;
                    req   <= 1'b0;
                end
            endcase
        end
    end

    AST_REQ_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> req);  // R3
    AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_sync) |=> req);  // R3
    AST_BUS_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req && !ack_sync) |=> $stable(bus_data));  // R4
    AST_NO_EARLY_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (!req && ack_sync) |=> (!req && !in_ready));  // R7
endmodule

// File: rtl/xdom_hs_receiver.sv
// Receiving side: samples the bus on the rising synchronized request,
// pulses valid once and runs the acknowledge half of the exchange.
// Assumes: req_sync is already synchronized into rcv_clk and the bus is
// stable while the request is pending.
module xdom_hs_receiver #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_sync,
    input  logic [DATA_W-1:0] bus_data,
    output logic              ack,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data
);
    logic req_seen;
    logic req_rise;

    assign req_rise = req_sync && !req_seen;

    // Remember the previous synchronized request for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) req_seen <= 1'b0;
        else        req_seen <= req_sync;
    end

    // Capture once per rising request and drive the acknowledge level.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ack       <= 1'b0;
            out_valid <= 1'b0;
            out_data  <= '0;
        end else begin
            out_valid <= req_rise;
            if (req_rise) begin
                out_data <= bus_data;
                ack      <= 1'b1;
            end else if (!req_sync) begin
                ack <= 1'b0;
            end
        end
    end

    AST_ONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |=> !out_valid);  // R5
    AST_ACK_WITH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack) |-> out_valid);  // R6
    AST_ACK_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && req_sync) |=> ack);  // R6
    AST_ACK_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !req_sync && !req_rise) |=> !ack);  // R6
endmodule

// File: rtl/xdom_word_handshake.sv
// Top level: word transfer between two clock domains by a four-phase
// request/acknowledge exchange with synchronizers in both directions.
// Assumes: the two resets are each synchronous to their own clock.
module xdom_word_handshake #(
    parameter int DATA_W      = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              snd_clk,
    input  logic              snd_rst_n,
    input  logic              snd_valid,
    input  logic [DATA_W-1:0] snd_data,
    output logic              snd_ready,
    input  logic              rcv_clk,
    input  logic              rcv_rst_n,
    output logic              rcv_valid,
    output logic [DATA_W-1:0] rcv_data
);
    logic              req;
    logic              ack;
    logic              req_sync;
    logic              ack_sync;
    logic [DATA_W-1:0] bus_data;

    xdom_hs_sender #(.DATA_W(DATA_W)) u_sender (
        .clk      (snd_clk),
        .rst_n    (snd_rst_n),
        .in_valid (snd_valid),
        .in_data  (snd_data),
        .in_ready (snd_ready),
        .ack_sync (ack_sync),
        .req      (req),
        .bus_data (bus_data)
    );

    xdom_bit_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk      (rcv_clk),
        .rst_n    (rcv_rst_n),
        .async_in (req),
        .sync_out (req_sync)
    );

    xdom_bit_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk      (snd_clk),
        .rst_n    (snd_rst_n),
        .async_in (ack),
        .sync_out (ack_sync)
    );

    xdom_hs_receiver #(.DATA_W(DATA_W)) u_receiver (
        .clk       (rcv_clk),
        .rst_n     (rcv_rst_n),
        .req_sync  (req_sync),
        .bus_data  (bus_data),
        .ack       (ack),
        .out_valid (rcv_valid),
        .out_data  (rcv_data)
    );
endmodule

// File: tb/tb_xdom_word_handshake.sv
module tb_xdom_word_handshake;
    localparam int DW = 16;

    logic          snd_clk = 1'b0, rcv_clk = 1'b0;
    logic          snd_rst_n = 1'b0, rcv_rst_n = 1'b0;
    logic          snd_valid = 1'b0;
    logic [DW-1:0] snd_data = '0;
    logic          snd_ready, rcv_valid;
    logic [DW-1:0] rcv_data;

    int errors = 0, checks = 0;
    logic [DW-1:0] exp_q [0:255];
    int wr_idx = 0, rd_idx = 0;
    logic prev_valid = 1'b0;

    always #2.5 snd_clk = ~snd_clk;   // 200 MHz
    always #3.7 rcv_clk = ~rcv_clk;   // unrelated receive clock

    xdom_word_handshake #(.DATA_W(DW)) dut (
        .snd_clk(snd_clk), .snd_rst_n(snd_rst_n), .snd_valid(snd_valid),
        .snd_data(snd_data), .snd_ready(snd_ready),
        .rcv_clk(rcv_clk), .rcv_rst_n(rcv_rst_n),
        .rcv_valid(rcv_valid), .rcv_data(rcv_data)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [DW-1:0] junk_word(input int k);
        return DW'(16'hDEAD ^ k);
    endfunction

    // Receive monitor: order, value, pulse width (R5, R8)
    always @(negedge rcv_clk) begin
        if (rcv_rst_n) begin
            if (rcv_valid) begin
                check(!prev_valid, "R5 pulse width", 2, 1);
                if (rd_idx < wr_idx) begin
                    check(rcv_data == exp_q[rd_idx[7:0]], "R8 order/value",
                          int'(rcv_data), int'(exp_q[rd_idx[7:0]]));
                end else begin
                    check(1'b0, "R2/R8 unexpected word", int'(rcv_data), -1);
                end
                rd_idx++;
            end
            prev_valid <= rcv_valid;
        end
    end

    // Offer one word; optionally offer junk while busy (R2, R3)
    task automatic send(input logic [DW-1:0] w, input bit junk);
        @(negedge snd_clk);
        while (!snd_ready) @(negedge snd_clk);
        snd_valid = 1'b1;
        snd_data  = w;
        exp_q[wr_idx[7:0]] = w;
        wr_idx++;
        @(negedge snd_clk);
        check(!snd_ready, "R3 busy after accept", int'(snd_ready), 0);
        if (junk) begin
            for (int k = 0; k < 3; k++) begin
                snd_data = junk_word(k);
                @(negedge snd_clk);
                check(!snd_ready, "R2 ready low while busy", int'(snd_ready), 0);
            end
        end
        snd_valid = 1'b0;
    endtask

    // Wait until sender idle again, bounded (R6, R7)
    task automatic wait_idle();
        int n = 0;
        while (!snd_ready && n < 60) begin
            @(negedge snd_clk);
            n++;
        end
        check(snd_ready, "R6/R7 return to idle", int'(snd_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge snd_clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (4) @(posedge rcv_clk);
        snd_rst_n = 1'b1;
        rcv_rst_n = 1'b1;
        @(negedge snd_clk);
        check(snd_ready == 1'b1, "R1 ready after reset", int'(snd_ready), 1);
        check(rcv_valid == 1'b0, "R1 valid after reset", int'(rcv_valid), 0);

        // Directed corners: extremes, busy offers
        send('0, 1'b0);
        wait_idle();
        send('1, 1'b1);
        wait_idle();
        send(16'hA5A5, 1'b1);
        // Back-to-back (no gap)
        send(16'h0001, 1'b0);
        send(16'h8000, 1'b0);
        wait_idle();

        // Random words with random gaps
        for (int i = 0; i < 40; i++) begin
            repeat ($urandom_range(0, 5)) @(negedge snd_clk);
            send(DW'($urandom), bit'($urandom_range(0, 1)));
        end
        wait_idle();
        repeat (20) @(negedge rcv_clk);
        check(rd_idx == wr_idx, "R8 count delivered", rd_idx, wr_idx);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule